// File: doc/BRIEF.md
# SPI Transfer Descriptor Builder

This block turns one transfer request (a starting table slot, a template word, a byte count and a buffer address) into a chain of descriptor words for a chained SPI master. It writes those words one after another into a descriptor table. A length that fits the unit-count field gives a single descriptor counted in bytes. A longer length is split into descriptors counted in 16-byte units, followed by a byte-unit descriptor for whatever is left. Each descriptor points at the slot after its own.

The block also picks the element width that a DMA engine should use. The choice depends on whether the buffer address and the length together are word aligned, halfword aligned or neither. That width goes out on its own pin and into every descriptor. When the chain is written, the block pulses a completion strobe. The strobe carries either the slot of the last descriptor or an error code, the error meaning the table ran out of slots.

Requests arrive on a valid/ready pair. `req_ready` is high only while the builder is idle, so a request offered while it is busy is simply not taken. Descriptor words leave on a valid/ready stream. When `wr_ready` is low the builder stalls, holding the word and its slot unchanged. With `wr_ready` high it produces one word per clock.

Top module: `spi_desc_builder`

## Requirements
- R1: When the remaining byte count is at most MAX = 2^CNT_W-1, the builder writes one descriptor. Its unit-size field (bits 9:8) is 0, meaning 1-byte units, and its count field (bits 17 upward, CNT_W wide) holds the remaining count.
- R2: When more than MAX bytes remain, the builder writes a descriptor with unit-size code 2 (16-byte units). Its count is min(remaining >> 4, MAX). It then subtracts count*16 from the remaining bytes and goes on with the next slot.
- R3: The first descriptor goes to the requested start slot, and each later one goes to the next slot up. Every descriptor's next-slot field (bits 15:12) holds its own slot + 1 modulo 2^IDX_W. A chain that succeeds reports its last slot in `done_idx` with `done_err` low.
- R4: If the slot would pass the last table entry (2^IDX_W - 1) while bytes remain, no write is made for it. `done` then pulses with `done_err` high and `done_idx` = 0xFFFF.
- R5: Let v be bit 1:0 of (address OR byte count). v = 00 selects 4-byte elements (code 3), v = 10 selects 2-byte elements (code 2), and any other v selects 1-byte elements (code 1). The code appears on `dma_width` from the cycle after acceptance, and in bits 5:4 of every descriptor.
- R6: Every descriptor bit outside the DMA, unit-size, next-slot and count fields is copied from the template. The template's own values in those four fields are discarded.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_data` and `wr_idx` hold steady. While `wr_ready` stays high, a new word is offered every cycle until the chain ends.
- R8: `req_ready` is low from acceptance until the completion pulse. A request offered in that time is ignored and changes neither the words written nor the result.
- R9: A zero byte count writes nothing. `done` pulses in the cycle after acceptance, with `done_idx` equal to the start slot and `done_err` low.
- R10: After reset, `req_ready` = 1, `wr_valid` = 0, `done` = 0 and `dma_width` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Builder idle; request taken when both high |
| req_start_idx | input | IDX_W | First descriptor slot |
| req_template | input | 32 | Template descriptor word |
| req_bytes | input | BYTES_W | Bytes to describe |
| req_addr | input | ADDR_W | Buffer address (low bits used for alignment) |
| wr_valid | output | 1 | Descriptor word offered |
| wr_ready | input | 1 | Table accepts the word |
| wr_idx | output | IDX_W | Table slot of the word |
| wr_data | output | 32 | Descriptor word |
| dma_width | output | 2 | Selected DMA element width code |
| done | output | 1 | One-cycle completion pulse |
| done_idx | output | 16 | Last slot written, or 0xFFFF on error |
| done_err | output | 1 | Table ran out of slots |

## Verification
The hardest cases to reach are two. One is a 16-byte-unit count that saturates at MAX, so that several full descriptors come before the remainder. The other is a chain that runs off the end of the table partway through. With the default count field, both need lengths of hundreds of kilobytes. The bench therefore builds the block with a 4-bit count field and a four-slot table. It then sweeps every byte count from 0 to 1023 against every start slot, which reaches saturation, multi-descriptor chains and exhaustion many times. Pseudo-random back-pressure on `wr_ready` runs throughout, and requests are injected while the builder is busy.

// File: rtl/spi_desc_pkg.sv
package spi_desc_pkg;

  localparam int DESC_W   = 32;
  localparam int DMA_LSB  = 4;
  localparam int UNIT_LSB = 8;
  localparam int NXT_LSB  = 12;
  localparam int NXT_W    = 4;
  localparam int CNT_LSB  = 17;

  typedef enum logic [1:0] {
    UNIT_1B  = 2'd0,
    UNIT_4B  = 2'd1,
    UNIT_16B = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    DMA_NONE = 2'd0,
    DMA_1B   = 2'd1,
    DMA_2B   = 2'd2,
    DMA_4B   = 2'd3
  } dma_e;

endpackage

// File: rtl/spi_desc_split.sv
module spi_desc_split
  import spi_desc_pkg::*;
#(
  parameter int BYTES_W = 32,
  parameter int CNT_W   = 15
) (
  input  logic [BYTES_W-1:0] rem,
  output unit_e              unit,
  output logic [CNT_W-1:0]   cnt,
  output logic [BYTES_W-1:0] consumed
);

  localparam logic [BYTES_W-1:0] MAX_B = {{(BYTES_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic [BYTES_W-1:0] q16;
  logic [BYTES_W-1:0] cnt_ext;

  always_comb begin
    q16 = rem >> 4;
    if (rem <= MAX_B) begin
      unit = UNIT_1B;
      cnt  = rem[CNT_W-1:0];
    end else begin
      unit = UNIT_16B;
      cnt  = (q16 > MAX_B) ? {CNT_W{1'b1}} : q16[CNT_W-1:0];
    end
    cnt_ext  = {{(BYTES_W-CNT_W){1'b0}}, cnt};
    consumed = (unit == UNIT_16B) ? (cnt_ext << 4) : cnt_ext;
  end

endmodule

// File: rtl/spi_desc_dma_sel.sv
module spi_desc_dma_sel
  import spi_desc_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] len_lo,
  output dma_e       code
);

  logic [1:0] merged;

  always_comb begin
    merged = addr_lo | len_lo;
    case (merged)
      2'b00:   code = DMA_4B;
      2'b10:   code = DMA_2B;
      default: code = DMA_1B;
    endcase
  end

endmodule

// File: rtl/spi_desc_fmt.sv
module spi_desc_fmt
  import spi_desc_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 15
) (
  input  logic [DESC_W-1:0] tmpl,
  input  unit_e             unit,
  input  logic [CNT_W-1:0]  cnt,
  input  dma_e              dma,
  input  logic [IDX_W-1:0]  own_idx,
  output logic [DESC_W-1:0] word
);

  logic [IDX_W-1:0] nxt;

  always_comb begin
    nxt  = own_idx + 1'b1;
    word = tmpl;
    word[DMA_LSB  +: 2]     = dma;
    word[UNIT_LSB +: 2]     = unit;
    word[NXT_LSB  +: NXT_W] = NXT_W'(nxt);
    word[CNT_LSB  +: CNT_W] = cnt;
  end

endmodule

// File: rtl/spi_desc_builder.sv
module spi_desc_builder
  import spi_desc_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 15,
  parameter int BYTES_W = 32,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_start_idx,
  input  logic [31:0]        req_template,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [31:0]        wr_data,
  output logic [1:0]         dma_width,
  output logic               done,
  output logic [15:0]        done_idx,
  output logic               done_err
);

  localparam logic [15:0] ERR_IDX = 16'hFFFF;

  logic               busy_q;
  logic [IDX_W:0]     idx_q;
  logic [BYTES_W-1:0] rem_q;
  logic [31:0]        tmpl_q;
  dma_e               dma_q;

  unit_e              s_unit;
  logic [CNT_W-1:0]   s_cnt;
  logic [BYTES_W-1:0] s_cons;
  dma_e               sel_code;
  logic [BYTES_W-1:0] rem_next;
  logic               idx_over;
  logic               accept;
  logic               hs;

  spi_desc_split #(.BYTES_W(BYTES_W), .CNT_W(CNT_W)) u_split (
    .rem      (rem_q),
    .unit     (s_unit),
    .cnt      (s_cnt),
    .consumed (s_cons)
  );

  spi_desc_dma_sel u_dma (
    .addr_lo (req_addr[1:0]),
    .len_lo  (req_bytes[1:0]),
    .code    (sel_code)
  );

  spi_desc_fmt #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_fmt (
    .tmpl    (tmpl_q),
    .unit    (s_unit),
    .cnt     (s_cnt),
    .dma     (dma_q),
    .own_idx (idx_q[IDX_W-1:0]),
    .word    (wr_data)
  );

  assign idx_over  = idx_q[IDX_W];
  assign req_ready = !busy_q;
  assign wr_valid  = busy_q && !idx_over;
  assign wr_idx    = idx_q[IDX_W-1:0];
  assign dma_width = dma_q;
  assign accept    = req_valid && req_ready;
  assign hs        = wr_valid && wr_ready;
  assign rem_next  = rem_q - s_cons;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      rem_q    <= '0;
      tmpl_q   <= '0;
      dma_q    <= DMA_NONE;
      done     <= 1'b0;
      done_idx <= '0;
      done_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        tmpl_q <= req_template;
        dma_q  <= sel_code;
        if (req_bytes == '0) begin
          done     <= 1'b1;
          done_idx <= 16'(req_start_idx);
          done_err <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= req_bytes;
          idx_q  <= {1'b0, req_start_idx};
        end
      end else if (busy_q) begin
        if (idx_over) begin
          busy_q   <= 1'b0;
          done     <= 1'b1;
          done_idx <= ERR_IDX;
          done_err <= 1'b1;
        end else if (hs) begin
          if (rem_next == '0) begin
            busy_q   <= 1'b0;
            done     <= 1'b1;
            done_idx <= 16'(idx_q[IDX_W-1:0]);
            done_err <= 1'b0;
          end else begin
            rem_q <= rem_next;
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  // R7: a stalled word stays put until taken
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_idx))
    else $error("p_hold_r7");

  // R8: no descriptor traffic while the request port is open
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wr_valid)
    else $error("p_idle_quiet_r8");

  // R9: completion reopens the request port
  p_done_reopens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready)
    else $error("p_done_reopens_r9");

  // R4: error strobe always carries the error code
  p_err_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> done_idx == ERR_IDX)
    else $error("p_err_code_r4");

  // R2: every accepted word retires at least one byte and no more than remain
  p_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> (s_cons != '0) && (s_cons <= rem_q))
    else $error("p_progress_r2");

  // R5: width choice frozen while a chain is in flight
  p_dma_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(dma_width))
    else $error("p_dma_frozen_r5");

endmodule

// File: tb/spi_desc_builder_tb.sv
module spi_desc_builder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W   = 2;
  localparam int CNT_W   = 4;
  localparam int BYTES_W = 12;
  localparam int ADDR_W  = 8;
  localparam int NSLOT   = 4;
  localparam int MAXC    = 15;
  localparam logic [31:0] KEEP_MASK =
    ~((32'h3 << 4) | (32'h3 << 8) | (32'hF << 12) | (32'hF << 17));

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [IDX_W-1:0]   req_start_idx = '0;
  logic [31:0]        req_template = '0;
  logic [BYTES_W-1:0] req_bytes = '0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic               wr_valid;
  logic               wr_ready = 1'b0;
  logic [IDX_W-1:0]   wr_idx;
  logic [31:0]        wr_data;
  logic [1:0]         dma_width;
  logic               done;
  logic [15:0]        done_idx;
  logic               done_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  spi_desc_builder #(.IDX_W(IDX_W), .CNT_W(CNT_W), .BYTES_W(BYTES_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_start_idx(req_start_idx), .req_template(req_template),
    .req_bytes(req_bytes), .req_addr(req_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .dma_width(dma_width), .done(done), .done_idx(done_idx), .done_err(done_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // back-pressure source
  logic [15:0] lfsr = 16'hACE1;
  bit          force_ready = 1'b0;
  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= force_ready | lfsr[0];
  end

  // reference model state
  bit          m_armed = 1'b0;
  bit          got_done = 1'b0;
  int          m_rem = 0;
  int          m_idx = 0;
  int          m_start = 0;
  int          m_bytes = 0;
  int          m_writes = 0;
  logic [31:0] m_tmpl = '0;
  int          m_dma = 0;
  bit          prev_stall = 1'b0;
  bit          prev_more = 1'b0;
  logic [31:0] prev_data = '0;
  logic [IDX_W-1:0] prev_idx = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(wr_valid && wr_data == prev_data && wr_idx == prev_idx, "R7 stalled word held",
            wr_data, prev_data);
      end
      if (prev_more) chk(wr_valid, "R7 back-to-back offer", wr_valid, 1);
      prev_stall = wr_valid && !wr_ready;
      prev_data  = wr_data;
      prev_idx   = wr_idx;
      prev_more  = 1'b0;
      if (wr_valid && wr_ready) begin
        int unit_e_v, cnt_e, cons;
        string tag;
        if (!m_armed || m_idx >= NSLOT) begin
          chk(0, "R8/R4 unexpected write", wr_idx, m_idx);
        end else begin
          if (m_rem <= MAXC) begin
            unit_e_v = 0; cnt_e = m_rem; cons = m_rem; tag = "R1";
          end else begin
            unit_e_v = 2; cnt_e = ((m_rem >> 4) > MAXC) ? MAXC : (m_rem >> 4);
            cons = cnt_e * 16; tag = "R2";
          end
          chk(wr_idx == m_idx[IDX_W-1:0], "R3 slot", wr_idx, m_idx);
          chk(wr_data[9:8] == 2'(unit_e_v), {tag, " unit size"}, wr_data[9:8], unit_e_v);
          chk(wr_data[20:17] == 4'(cnt_e), {tag, " count"}, wr_data[20:17], cnt_e);
          chk(wr_data[15:12] == 4'((m_idx + 1) % NSLOT), "R3 next slot",
              wr_data[15:12], (m_idx + 1) % NSLOT);
          chk(wr_data[5:4] == 2'(m_dma), "R5 descriptor dma field", wr_data[5:4], m_dma);
          chk((wr_data & KEEP_MASK) == (m_tmpl & KEEP_MASK), "R6 template copy",
              wr_data & KEEP_MASK, m_tmpl & KEEP_MASK);
          m_writes++;
          m_rem -= cons;
          if (m_rem > 0) begin
            m_idx++;
            prev_more = (m_idx < NSLOT);
          end
        end
      end
      if (done) begin
        if (!m_armed) begin
          chk(0, "R8 unexpected done", done, 0);
        end else if (m_rem > 0) begin
          chk(done_err == 1'b1 && done_idx == 16'hFFFF, "R4 out of slots",
              {done_err, done_idx}, 32'h1FFFF);
        end else if (m_bytes == 0) begin
          chk(done_err == 1'b0 && done_idx == 16'(m_start) && m_writes == 0,
              "R9 zero length result", done_idx, m_start);
        end else begin
          chk(done_err == 1'b0 && done_idx == 16'(m_idx), "R3 last slot", done_idx, m_idx);
        end
        if (m_armed) chk(dma_width == 2'(m_dma), "R5 dma width port", dma_width, m_dma);
        m_armed  = 1'b0;
        got_done = 1'b1;
      end
    end
  end

  task automatic run_txn(input int start, input int bytes, input bit rogue);
    logic [7:0] addr;
    int lo;
    addr = 8'(bytes * 3 + start * 5);
    lo   = (addr[1:0] | 2'(bytes)) & 3;
    @(negedge clk);
    chk(req_ready, "R8 idle before request", req_ready, 1);
    req_start_idx = IDX_W'(start);
    req_bytes     = BYTES_W'(bytes);
    req_addr      = addr;
    req_template  = 32'hC3A5_9B6D ^ 32'(bytes << 11) ^ 32'(start);
    m_tmpl   = req_template;
    m_dma    = (lo == 0) ? 3 : (lo == 2) ? 2 : 1;
    m_rem    = bytes;
    m_bytes  = bytes;
    m_idx    = start;
    m_start  = start;
    m_writes = 0;
    m_armed  = 1'b1;
    got_done = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bytes == 0) chk(done == 1'b1, "R9 done one cycle after accept", done, 1);
    if (rogue && !req_ready) begin
      req_valid     = 1'b1;
      req_start_idx = '0;
      req_bytes     = BYTES_W'(5);
      req_addr      = 8'h01;
      req_template  = 32'hFFFF_FFFF;
      @(negedge clk);
      chk(1'b1, "R8 busy request offered", 0, 0);
      req_valid = 1'b0;
    end
    while (!got_done) @(negedge clk);
    @(negedge clk);
    chk(!wr_valid && !done && req_ready, "R8 quiet after completion",
        {wr_valid, done, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    chk(wr_valid == 1'b0, "R10 reset wr_valid", wr_valid, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(dma_width == 2'd0, "R10 reset dma_width", dma_width, 0);
    rst_n = 1'b1;
    // full-throughput pass for R7 cadence
    force_ready = 1'b1;
    for (int b = 0; b < 300; b += 7) run_txn(b % NSLOT, b, 1'b0);
    force_ready = 1'b0;
    // exhaustive sweep with back-pressure
    for (int b = 0; b < 1024; b++) begin
      for (int s = 0; s < NSLOT; s++) run_txn(s, b, (b % 37) == 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule